// File: doc/BRIEF.md
# Jumbo-Prefix Instruction Length Decoder

This fetch-side block takes a window of up to three 32-bit words that begins at the current instruction address. It decides from the first word alone whether the instruction is a plain 32-bit word, a 64-bit form led by a short jumbo prefix, or a 96-bit form led by a long jumbo prefix. It then assembles the full immediate, sign-extends it to 64 bits, and works out the next sequential address and the PC-relative branch target.

Windows arrive on a valid/ready handshake together with the address of their first word. Each accepted window produces one registered result on an output valid/ready handshake. If the window holds fewer valid words than the decoded length, the block raises a stall. It does not take the window, and the fetch side must refill the window before the block can accept it. The two prefix opcode values are parameters.

Top module: `jumbo_len_decoder`

## Requirements
- R1: The length depends only on bits [6:0] of `in_w0`. The value SHORT_OP (default 7'h0B) gives length 2. The value LONG_OP (default 7'h2B) gives length 3. Any other value gives length 1. `out_len` carries the length in words.
- R2: For length 1, `out_imm` is bits [31:20] of word 0, sign-extended to 64 bits.
- R3: For length 2, `out_imm` is the 33-bit value {w0[31:11], w1[31:20]}, sign-extended to 64 bits.
- R4: For length 3, `out_imm` is {w0[31:12], w1[31:0], w2[31:20]}, which forms 64 bits.
- R5: `out_next_pc` equals the window address plus 4, 8 or 12 for lengths 1, 2 or 3, computed modulo 2^64.
- R6: `out_br_tgt` equals the address of the first word (the prefix, when there is one) plus `out_imm`. It is not based on the address of the following instruction.
- R7: `out_illegal` is set when word 0 and word 1 both carry SHORT_OP in bits [6:0]. This marks the retired double-short-prefix form. In every other case `out_illegal` is clear.
- R8: When `in_valid` is high and `in_cnt` is below the decoded length, `stall` is high, `in_ready` is low and no result is produced.
- R9: Apart from a stall, `in_ready` is high exactly when no result is held or `out_ready` is high. A result that is held while `out_ready` is low keeps all its fields unchanged.
- R10: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window present |
| in_ready | output | 1 | Window accepted this cycle when high together with in_valid |
| in_w0 | input | 32 | Word at the instruction address |
| in_w1 | input | 32 | Following word |
| in_w2 | input | 32 | Word after that |
| in_cnt | input | 2 | Number of valid words in the window (0 to 3) |
| in_pc | input | 64 | Address of in_w0 |
| stall | output | 1 | Window too short for the decoded length |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 2 | Instruction length in words |
| out_imm | output | 64 | Assembled, sign-extended immediate |
| out_pc | output | 64 | Address of the decoded instruction |
| out_next_pc | output | 64 | Next sequential address |
| out_br_tgt | output | 64 | Instruction address plus immediate |
| out_illegal | output | 1 | Retired double-short-prefix form detected |

## Verification
On every cycle the assertions check the following: a held result never reports length zero, the gap between the next address and the instruction address matches the length, the branch target is the instruction address plus the immediate, and a short immediate is a proper sign extension. They also check that a stall blocks acceptance and that a result waiting under back-pressure stays frozen. The exact field slices behind each immediate form, the choice of length from the opcode, the illegal double-prefix pattern and the wrap of the address at the top of memory are shown only by the bench. The bench drives directed and random windows and compares each result against its own model.

// File: rtl/jumbo_len_decoder.sv
module jumbo_len_decoder #(
  parameter logic [6:0] SHORT_OP = 7'h0B,
  parameter logic [6:0] LONG_OP  = 7'h2B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_w0,
  input  logic [31:0] in_w1,
  input  logic [31:0] in_w2,
  input  logic [1:0]  in_cnt,
  input  logic [63:0] in_pc,
  output logic        stall,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_len,
  output logic [63:0] out_imm,
  output logic [63:0] out_pc,
  output logic [63:0] out_next_pc,
  output logic [63:0] out_br_tgt,
  output logic        out_illegal
);

  logic        is_short, is_long, take;
  logic [1:0]  len_d;
  logic [63:0] imm_d;
  logic [32:0] imm33;

  assign is_short = in_w0[6:0] == SHORT_OP;
  assign is_long  = in_w0[6:0] == LONG_OP;
  assign len_d    = is_long ? 2'd3 : (is_short ? 2'd2 : 2'd1);
  assign imm33    = {in_w0[31:11], in_w1[31:20]};

  always_comb begin
    case (len_d)
      2'd3:    imm_d = {in_w0[31:12], in_w1, in_w2[31:20]};
      2'd2:    imm_d = {{31{imm33[32]}}, imm33};
      default: imm_d = {{52{in_w0[31]}}, in_w0[31:20]};
    endcase
  end

  assign stall    = in_valid && (in_cnt < len_d);
  assign in_ready = (!out_valid || out_ready) && !stall;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (take)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_len     <= len_d;
      out_imm     <= imm_d;
      out_pc      <= in_pc;
      out_next_pc <= in_pc + {60'd0, len_d, 2'b00};
      out_br_tgt  <= in_pc + imm_d;
      out_illegal <= is_short && (in_w1[6:0] == SHORT_OP);
    end
  end

  p_len_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len != 2'd0);

  p_sext_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 2'd1) |->
      ($countones(out_imm[63:11]) == 0 || $countones(out_imm[63:11]) == 53));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_next_pc - out_pc) == {60'd0, out_len, 2'b00});

  p_tgt_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_br_tgt == out_pc + out_imm);

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_imm) &&
      $stable(out_pc) && $stable(out_len) && $stable(out_illegal)));

endmodule

// File: tb/jumbo_len_decoder_bench.sv
module jumbo_len_decoder_bench;
  localparam logic [6:0] SOP = 7'h0B;
  localparam logic [6:0] LOP = 7'h2B;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [31:0] w0 = 0, w1 = 0, w2 = 0;
  logic [1:0] cnt = 0;
  logic [63:0] pc = 0;
  logic in_ready, stall, out_valid, out_illegal;
  logic [1:0] out_len;
  logic [63:0] out_imm, out_pc, out_next_pc, out_br_tgt;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  jumbo_len_decoder #(.SHORT_OP(SOP), .LONG_OP(LOP)) u_jumbo_len_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_w0(w0), .in_w1(w1), .in_w2(w2), .in_cnt(cnt), .in_pc(pc),
    .stall(stall), .out_valid(out_valid), .out_ready(out_ready),
    .out_len(out_len), .out_imm(out_imm), .out_pc(out_pc),
    .out_next_pc(out_next_pc), .out_br_tgt(out_br_tgt), .out_illegal(out_illegal));

  function automatic int rlen(logic [31:0] a);
    if (a[6:0] == LOP) return 3;
    if (a[6:0] == SOP) return 2;
    return 1;
  endfunction

  function automatic longint rimm(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    longint s;
    case (rlen(a))
      1: s = longint'($signed(a)) >>> 20;
      2: s = ((longint'($signed(a)) >>> 11) <<< 12) | longint'(b >> 20);
      default: s = (longint'(a >> 12) << 44) | (longint'(b) << 12) | longint'(c >> 20);
    endcase
    return s;
  endfunction

  logic        e_valid = 0, e_ill = 0;
  int          e_len = 0;
  logic [63:0] e_imm = 0, e_pc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) e_valid <= 0;
    else if (in_valid && (!e_valid || out_ready) && cnt >= rlen(w0)) begin
      e_valid <= 1;
      e_len   <= rlen(w0);
      e_imm   <= rimm(w0, w1, w2);
      e_pc    <= pc;
      e_ill   <= (w0[6:0] == SOP) && (w1[6:0] == SOP);
    end else if (out_ready) e_valid <= 0;
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_regs();
    chk(out_valid === e_valid, "R9/R10 out_valid", 64'(out_valid), 64'(e_valid));
    if (e_valid) begin
      chk(out_len === 2'(e_len), "R1 length", 64'(out_len), 64'(e_len));
      chk(out_imm === e_imm, e_len == 1 ? "R2 imm" : (e_len == 2 ? "R3 imm" : "R4 imm"),
          out_imm, e_imm);
      chk(out_next_pc === e_pc + 64'(4 * e_len), "R5 next pc", out_next_pc, e_pc + 64'(4 * e_len));
      chk(out_br_tgt === e_pc + e_imm, "R6 branch target", out_br_tgt, e_pc + e_imm);
      chk(out_illegal === e_ill, "R7 illegal", 64'(out_illegal), 64'(e_ill));
    end
  endtask

  task automatic step(bit v, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                      logic [1:0] n, logic [63:0] p, bit ordy);
    bit st;
    @(negedge clk);
    cmp_regs();
    in_valid = v; w0 = a; w1 = b; w2 = c; cnt = n; pc = p; out_ready = ordy;
    #1;
    st = v && (int'(n) < rlen(a));
    chk(stall === st, "R8 stall", 64'(stall), 64'(st));
    chk(in_ready === ((!e_valid || ordy) && !st), "R9 in_ready", 64'(in_ready),
        64'((!e_valid || ordy) && !st));
  endtask

  function automatic logic [31:0] mk(logic [6:0] op);
    logic [31:0] r = $urandom;
    r[6:0] = op;
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1;
    // R2 plain, negative and positive immediates
    step(1, 32'hFFF0_0013, 0, 0, 1, 64'h1000, 1);
    step(1, 32'h7FF0_0013, 0, 0, 1, 64'h1004, 1);
    // R3 short prefix, R6 target relative to prefix address
    step(1, {21'h10_0000, 4'h0, SOP}, 32'hABC0_0063, 0, 2, 64'h2000, 1);
    // R4 long prefix, R5 wrap at top of memory
    step(1, {20'h8_1234, 5'h0, LOP}, 32'hDEAD_BEEF, 32'h5670_0013, 3, 64'hFFFF_FFFF_FFFF_FFF8, 1);
    // R7 retired double-short form
    step(1, {25'h0, SOP}, {25'h1, SOP}, 32'h0000_0037, 3, 64'h3000, 1);
    // R8 stalls: short window for length 3 and 2, then refill
    step(1, {25'h1, LOP}, 32'h1, 32'h2, 2, 64'h4000, 1);
    step(1, {25'h1, SOP}, 32'h1, 32'h2, 1, 64'h4000, 1);
    step(1, 32'h0000_0013, 0, 0, 0, 64'h4000, 1);
    step(1, {25'h1, LOP}, 32'h1, 32'h2, 3, 64'h4000, 1);
    // R9 back-pressure holds the result
    step(1, mk(SOP), $urandom, $urandom, 3, 64'h5000, 0);
    step(1, mk(LOP), $urandom, $urandom, 3, 64'h6000, 0);
    step(1, mk(LOP), $urandom, $urandom, 3, 64'h6000, 0);
    step(1, mk(LOP), $urandom, $urandom, 3, 64'h6000, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 2);
      logic [6:0] op = (k == 0) ? SOP : (k == 1 ? LOP : 7'h13);
      logic [6:0] op1 = ($urandom_range(0, 3) == 0) ? SOP : 7'h33;
      step($urandom_range(0, 3) != 0, mk(op), mk(op1), $urandom, 2'($urandom_range(0, 3)),
           {$urandom, $urandom} & ~64'd3, $urandom_range(0, 2) != 0);
    end
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule